// File: doc/BRIEF.md
# Gap2 Write-Gate and VCO-Enable Timer

This block measures the gap that separates the ID field of a sector from its data field. It counts in byte times. An end-of-ID pulse starts the count, and each byte-time enable advances it by one. From the count the block derives three outputs, each at a fixed byte position.

- **Sync start** is a one-cycle pulse that marks where the sync field begins.
- **Write gate** opens for write and format operations.
- **VCO enable** is given to the read data separator on reads. It is raised two bytes after the sync field begins, which leaves margin for motor speed drift.

Two selects choose the timing. In conventional timing the gap is 22 bytes and the write gate opens exactly at the sync field. Perpendicular drives carry an erase element ahead of the write head. For them the write gate opens early, at byte 3 of the gap, so that the erase element has already cleared the old flux when the new sync field is laid down. At the fast data rate the gap is also stretched to 41 bytes, and the sync and VCO positions move with it.

The operation type and timing selects are captured when the end-of-ID pulse arrives. The write gate is then held until the data field ends. The VCO enable is held until the operation completes.

Top module: `gap2_timer`

## Requirements
- R1: After reset `wrGate`, `vcoEn` and `syncStart` are all 0.
- R2: With conventional gap length (22 bytes), `syncStart` is high for exactly one clock cycle. That cycle follows the clock edge on which the 22nd `byteTick` after the `idEnd` pulse is taken. The pulse does not recur for later ticks.
- R3: The long gap of 41 bytes is used when `perpWgate`=1 and either `perpGap`=1 or `rateSel`=2'b11 (the 1 Mbps code). In that case `syncStart` comes on the 41st tick.
- R4: With `perpWgate`=0 and `opWrite`=1 (write or format), `wrGate` rises on the same edge as `syncStart`, which is the tick that equals the gap length.
- R5: With `perpWgate`=1 and `opWrite`=1, `wrGate` rises on the 3rd tick after `idEnd`, inside the gap. This holds at either gap length.
- R6: With `opWrite`=0 (read), `vcoEn` rises on the tick that equals the gap length plus 2: tick 24 for the conventional gap, tick 43 for the long gap. With `opWrite`=1, `vcoEn` stays 0 and `wrGate` never rises on a read.
- R7: Once raised, `wrGate` stays high through any further ticks. It falls on the edge on which `dataEnd`=1 is taken.
- R8: Once raised, `vcoEn` stays high through any further ticks. It falls on the edge on which `opDone`=1 is taken.
- R9: `opWrite`, `perpWgate`, `perpGap` and `rateSel` are sampled on the `idEnd` pulse. Changes to them during the count have no effect on any output position.
- R10: Counting stops at gap length plus 2, so later ticks produce no further output change. A new `idEnd` pulse restarts the count from zero, even during a count. When `idEnd` and `byteTick` are high in the same cycle, the restart takes precedence.
- R11: `perpGap`=1 with `perpWgate`=0 selects conventional timing at every rate: the gap is 22 bytes and the write gate opens at the sync field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byteTick | input | 1 | One-cycle enable per byte time |
| idEnd | input | 1 | One-cycle pulse at the end of the ID field (start of the gap) |
| opWrite | input | 1 | 1 = write or format operation, 0 = read |
| perpWgate | input | 1 | Perpendicular timing: early write gate |
| perpGap | input | 1 | Perpendicular timing: force the long gap |
| rateSel | input | 2 | Data rate code; 2'b11 = 1 Mbps |
| dataEnd | input | 1 | End of data field and CRC; closes the write gate |
| opDone | input | 1 | Operation complete; drops VCO enable |
| wrGate | output | 1 | Write gate |
| vcoEn | output | 1 | VCO enable for the read data separator |
| syncStart | output | 1 | One-cycle pulse at the start of the sync field |

## Verification
Every output is a register that is loaded on the clock edge that takes the byte tick it depends on. A result is therefore visible one edge after its tick, and `syncStart` falls again on the next edge. The bench drives each tick for one cycle starting at a falling edge and samples the outputs at the falling edge that follows the taking edge. It checks all three outputs after every tick and again during the idle cycles between ticks, so a pulse that lasts too long or an output that arrives one tick early or late is reported. `dataEnd` and `opDone` take effect on the edge that samples them, and the bench checks the outputs half a cycle after that edge.

// File: rtl/gap2_pkg.sv
package gap2_pkg;
  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic load;   // capture config, zero the counter
    logic step;   // advance the counter by one byte
  } ctlStrobe_t;

  // Compare results returned by the datapath (for the next count value)
  typedef struct packed {
    logic hitWr;
    logic hitSync;
    logic hitVco;
    logic isWrite;
  } dpHits_t;
endpackage

// File: rtl/gap2_datapath.sv
module gap2_datapath
  import gap2_pkg::*;
#(
  parameter int CONV_GAP   = 22,
  parameter int PERP_GAP   = 41,
  parameter int VCO_MARGIN = 2,
  parameter int ERASE_OPEN = 3,
  parameter int RATE_W     = 2,
  parameter logic [RATE_W-1:0] RATE_FAST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  input  logic              opWrite,
  input  logic              perpWgate,
  input  logic              perpGap,
  input  logic [RATE_W-1:0] rateSel,
  output dpHits_t           hits
);
  localparam int MAX_GAP = (PERP_GAP > CONV_GAP) ? PERP_GAP : CONV_GAP;
  localparam int CNT_W   = $clog2(MAX_GAP + VCO_MARGIN + 2);

  logic             cfgWrite, cfgEarly, cfgLong;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nxtCnt, gapLen, wrThr, vcoThr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgWrite <= 1'b0;
      cfgEarly <= 1'b0;
      cfgLong  <= 1'b0;
      cnt      <= '0;
    end else if (strobe.load) begin
      cfgWrite <= opWrite;
      cfgEarly <= perpWgate;
      cfgLong  <= perpWgate & (perpGap | (rateSel == RATE_FAST));
      cnt      <= '0;
    end else if (strobe.step) begin
      cnt <= nxtCnt;
    end
  end

  always_comb begin
    nxtCnt = cnt + 1'b1;
    gapLen = cfgLong ? CNT_W'(PERP_GAP) : CNT_W'(CONV_GAP);
    wrThr  = cfgEarly ? CNT_W'(ERASE_OPEN) : gapLen;
    vcoThr = gapLen + CNT_W'(VCO_MARGIN);
    hits.hitWr   = (nxtCnt == wrThr);
    hits.hitSync = (nxtCnt == gapLen);
    hits.hitVco  = (nxtCnt == vcoThr);
    hits.isWrite = cfgWrite;
  end
endmodule

// File: rtl/gap2_ctrl.sv
module gap2_ctrl
  import gap2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byteTick,
  input  logic       idEnd,
  input  logic       dataEnd,
  input  logic       opDone,
  input  dpHits_t    hits,
  output ctlStrobe_t strobe,
  output logic       wrGate,
  output logic       vcoEn,
  output logic       syncStart
);
  typedef enum logic {IDLE, COUNT} state_t;
  state_t state;

  always_comb begin
    strobe.load = idEnd;
    strobe.step = (state == COUNT) && byteTick && !idEnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      wrGate    <= 1'b0;
      vcoEn     <= 1'b0;
      syncStart <= 1'b0;
    end else begin
      syncStart <= strobe.step && hits.hitSync;

      if (strobe.load)
        state <= COUNT;
      else if (strobe.step && hits.hitVco)
        state <= IDLE;

      if (dataEnd)
        wrGate <= 1'b0;
      else if (strobe.step && hits.hitWr && hits.isWrite)
        wrGate <= 1'b1;

      if (opDone)
        vcoEn <= 1'b0;
      else if (strobe.step && hits.hitVco && !hits.isWrite)
        vcoEn <= 1'b1;
    end
  end
endmodule

// File: rtl/gap2_timer.sv
module gap2_timer
  import gap2_pkg::*;
#(
  parameter int CONV_GAP   = 22,
  parameter int PERP_GAP   = 41,
  parameter int VCO_MARGIN = 2,
  parameter int ERASE_OPEN = 3,
  parameter int RATE_W     = 2,
  parameter logic [RATE_W-1:0] RATE_FAST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byteTick,
  input  logic              idEnd,
  input  logic              opWrite,
  input  logic              perpWgate,
  input  logic              perpGap,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              dataEnd,
  input  logic              opDone,
  output logic              wrGate,
  output logic              vcoEn,
  output logic              syncStart
);
  ctlStrobe_t strobe;
  dpHits_t    hits;

  gap2_datapath #(
    .CONV_GAP(CONV_GAP), .PERP_GAP(PERP_GAP), .VCO_MARGIN(VCO_MARGIN),
    .ERASE_OPEN(ERASE_OPEN), .RATE_W(RATE_W), .RATE_FAST(RATE_FAST)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .opWrite(opWrite),
    .perpWgate(perpWgate), .perpGap(perpGap), .rateSel(rateSel), .hits(hits)
  );

  gap2_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .byteTick(byteTick), .idEnd(idEnd),
    .dataEnd(dataEnd), .opDone(opDone), .hits(hits), .strobe(strobe),
    .wrGate(wrGate), .vcoEn(vcoEn), .syncStart(syncStart)
  );
endmodule

// File: rtl/gap2_timer_chk.sv
module gap2_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic byteTick,
  input logic dataEnd,
  input logic opDone,
  input logic wrGate,
  input logic vcoEn,
  input logic syncStart
);
  // R2
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syncStart |=> !syncStart);
  // R2
  sync_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syncStart |-> $past(byteTick));
  // R5
  wr_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrGate) |-> $past(byteTick));
  // R6
  vco_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcoEn) |-> $past(byteTick));
  // R7
  wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dataEnd |=> !wrGate);
  // R8
  vco_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opDone |=> !vcoEn);
endmodule

bind gap2_timer gap2_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byteTick(byteTick), .dataEnd(dataEnd),
  .opDone(opDone), .wrGate(wrGate), .vcoEn(vcoEn), .syncStart(syncStart)
);

// File: tb/gap2_timer_test.sv
module gap2_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byteTick = 0, idEnd = 0, opWrite = 0, perpWgate = 0, perpGap = 0;
  logic [1:0] rateSel = 2'b00;
  logic dataEnd = 0, opDone = 0;
  logic wrGate, vcoEn, syncStart;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gap2_timer uut (
    .clk(clk), .rst_n(rst_n), .byteTick(byteTick), .idEnd(idEnd),
    .opWrite(opWrite), .perpWgate(perpWgate), .perpGap(perpGap),
    .rateSel(rateSel), .dataEnd(dataEnd), .opDone(opDone),
    .wrGate(wrGate), .vcoEn(vcoEn), .syncStart(syncStart)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic startGap(logic w, logic wg, logic gp, logic [1:0] rt);
    @(negedge clk);
    opWrite = w; perpWgate = wg; perpGap = gp; rateSel = rt; idEnd = 1'b1;
    @(negedge clk);
    idEnd = 1'b0;
  endtask

  task automatic oneTick();
    byteTick = 1'b1;
    @(negedge clk);
    byteTick = 1'b0;
  endtask

  // Runs n ticks after a started gap, checking each output after every tick
  task automatic runTicks(int n, logic w, int gapLen, int wrThr,
                          string sTag, string wTag);
    for (int k = 1; k <= n; k++) begin
      oneTick();
      check(sTag, $sformatf("syncStart tick %0d", k), syncStart, k == gapLen);
      check(wTag, $sformatf("wrGate tick %0d", k), wrGate, w && k >= wrThr);
      check("R6", $sformatf("vcoEn tick %0d", k), vcoEn, !w && k >= gapLen + 2);
      idle(1);
      check(sTag, $sformatf("syncStart idle %0d", k), syncStart, 1'b0);
    end
  endtask

  task automatic closeOut();
    @(negedge clk); dataEnd = 1'b1; opDone = 1'b1;
    @(negedge clk); dataEnd = 1'b0; opDone = 1'b0;
    check("R7", "wrGate after dataEnd", wrGate, 1'b0);
    check("R8", "vcoEn after opDone", vcoEn, 1'b0);
  endtask

  task automatic gapCase(logic w, logic wg, logic gp, logic [1:0] rt,
                         string sTag, string wTag);
    int gapLen = (wg && (gp || rt == 2'b11)) ? 41 : 22;
    int wrThr  = wg ? 3 : gapLen;
    startGap(w, wg, gp, rt);
    runTicks(gapLen + 5, w, gapLen, wrThr, sTag, wTag);
    closeOut();
  endtask

  task automatic testReset();
    check("R1", "wrGate reset", wrGate, 1'b0);
    check("R1", "vcoEn reset", vcoEn, 1'b0);
    check("R1", "syncStart reset", syncStart, 1'b0);
  endtask

  task automatic testHolds();
    // R7 wrGate held until dataEnd only; R8 vcoEn held until opDone only
    startGap(1'b1, 1'b1, 1'b0, 2'b00);
    runTicks(30, 1'b1, 22, 3, "R2", "R5");
    @(negedge clk); opDone = 1'b1; @(negedge clk); opDone = 1'b0;
    check("R7", "wrGate kept over opDone", wrGate, 1'b1);
    @(negedge clk); dataEnd = 1'b1; @(negedge clk); dataEnd = 1'b0;
    check("R7", "wrGate dropped by dataEnd", wrGate, 1'b0);
    startGap(1'b0, 1'b0, 1'b0, 2'b00);
    runTicks(26, 1'b0, 22, 22, "R2", "R6");
    @(negedge clk); dataEnd = 1'b1; @(negedge clk); dataEnd = 1'b0;
    check("R8", "vcoEn kept over dataEnd", vcoEn, 1'b1);
    @(negedge clk); opDone = 1'b1; @(negedge clk); opDone = 1'b0;
    check("R8", "vcoEn dropped by opDone", vcoEn, 1'b0);
  endtask

  task automatic testCfgIgnored();
    // R9: start with perpendicular fast write, then flip inputs mid-gap
    startGap(1'b1, 1'b1, 1'b0, 2'b11);
    opWrite = 1'b0; perpWgate = 1'b0; rateSel = 2'b00;
    runTicks(45, 1'b1, 41, 3, "R9", "R9");
    closeOut();
  endtask

  task automatic testRestart();
    // R10: restart during count, with a tick in the same cycle as idEnd
    startGap(1'b0, 1'b0, 1'b0, 2'b00);
    runTicks(10, 1'b0, 22, 22, "R10", "R10");
    @(negedge clk);
    idEnd = 1'b1; byteTick = 1'b1;
    @(negedge clk);
    idEnd = 1'b0; byteTick = 1'b0;
    runTicks(60, 1'b0, 22, 22, "R10", "R10");
    closeOut();
    for (int k = 0; k < 5; k++) begin
      oneTick();
      check("R10", "no output without idEnd", syncStart | vcoEn | wrGate, 1'b0);
    end
  endtask

  initial begin
    idle(3);
    testReset();
    rst_n = 1'b1;
    idle(2);
    testReset();
    gapCase(1'b0, 1'b0, 1'b0, 2'b00, "R2", "R6");   // conventional read
    gapCase(1'b1, 1'b0, 1'b0, 2'b11, "R2", "R4");   // conventional write, fast rate
    gapCase(1'b1, 1'b1, 1'b0, 2'b11, "R3", "R5");   // perpendicular fast write
    gapCase(1'b1, 1'b1, 1'b0, 2'b00, "R2", "R5");   // perpendicular slow write
    gapCase(1'b0, 1'b1, 1'b0, 2'b11, "R3", "R6");   // perpendicular fast read
    gapCase(1'b0, 1'b1, 1'b1, 2'b00, "R3", "R6");   // forced long gap, slow rate
    gapCase(1'b1, 1'b0, 1'b1, 2'b11, "R11", "R11"); // gap bit alone: conventional
    gapCase(1'b0, 1'b0, 1'b1, 2'b11, "R11", "R6");
    testHolds();
    testCfgIgnored();
    testRestart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule